// File: doc/BRIEF.md
# Machine Double-Trap Escalation Controller

This block holds the machine-level trap-disable flag and the machine interrupt enable, and judges every trap aimed at machine mode. A trap is expected when the disable flag is clear. In that case the flag is raised and the trap goes ahead. A trap is unexpected when the flag is already set. When resumable NMIs are supported, a trap raised while executing in machine mode with the NMI enable low is also unexpected.

An unexpected trap has one of two outcomes. If resumable NMIs are supported and enabled, the trap is redirected to the NMI handler. The block then captures the pc and cause the trap would have recorded, sets the NMI previous-mode field to machine mode, and pulses a request to clear the NMI enable. Otherwise the hart is frozen and a critical-error signal is raised to the platform. Every architectural value held here stays as it was, and the halt and global interrupt mask outputs rise.

MIE changes only through explicit status writes. A compile-time parameter selects between two register layouts. In the wide layout the disable flag and MIE share one status word. In the split layout the flag sits in a separate high half-word.

Top module: `mdt_escalate`

## Requirements
- R1: After reset the disable flag (mdt_o) is 1, mie_o is 0, crit_err_o, halt_o, irq_mask_o, trap_ok_o and nmi_en_clr_o are 0, and nmi_epc_o, nmi_cause_o and nmi_prev_mode_o are 0.
- R2: In the wide layout, a status write (st_we) with st_mdt_d=1 leaves mie_o at 0 whatever st_mie_d holds.
- R3: MIE becomes 1 only through a write with st_mie_d=1. In the wide layout this needs the same write to carry st_mdt_d=0. In the split layout it needs mdt_o to be 0 already; otherwise the write leaves mie_o at 0.
- R4: In the split layout, a high-half write (sth_we) with sth_mdt_d=1 sets the flag and forces mie_o to 0, even if a status write arrives in the same cycle. In the wide layout sth_we has no effect.
- R5: A trap with mdt_o=0 that is not unexpected under R7 sets mdt_o to 1 and pulses trap_ok_o for one cycle, one cycle after the request.
- R6: An unexpected trap with nmi_resumable=1 and nmi_en=1 takes effect one cycle later. It loads nmi_epc_o with trap_pc and nmi_cause_o with trap_cause, sets nmi_prev_mode_o to 2'b11, and pulses nmi_en_clr_o for one cycle. mdt_o and mie_o stay unchanged and trap_ok_o stays 0.
- R7: With nmi_resumable=1, a trap raised with trap_in_m=1 and nmi_en=0 is unexpected even when mdt_o=0. With trap_in_m=0 it is not unexpected.
- R8: An unexpected trap with nmi_resumable=0, or with nmi_en=0, raises crit_err_o, halt_o and irq_mask_o one cycle later. mdt_o, mie_o and the NMI capture outputs are left unchanged.
- R9: Once raised, crit_err_o stays high until reset. While it is high, writes, MRET retirements and traps change no output.
- R10: Retiring an MRET (mret_retire) clears mdt_o to 0.
- R11: Within one cycle, a trap request outranks an MRET, and an MRET outranks status writes. The lower-ranked event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_we | input | 1 | Explicit write to the status word |
| st_mie_d | input | 1 | MIE value carried by the status write |
| st_mdt_d | input | 1 | Disable-flag value carried by the status write (wide layout) |
| sth_we | input | 1 | Explicit write to the high status half-word (split layout) |
| sth_mdt_d | input | 1 | Disable-flag value carried by the high-half write |
| trap_req | input | 1 | A trap into machine mode is requested this cycle |
| trap_in_m | input | 1 | The trapping instruction was executing in machine mode |
| trap_cause | input | CAUSE_W | Cause the trap would record |
| trap_pc | input | PC_W | Exception pc the trap would record |
| mret_retire | input | 1 | An MRET retires this cycle |
| nmi_resumable | input | 1 | Resumable NMIs are supported |
| nmi_en | input | 1 | Current NMI enable bit |
| mdt_o | output | 1 | Machine trap-disable flag |
| mie_o | output | 1 | Machine interrupt enable |
| trap_ok_o | output | 1 | One-cycle pulse: an expected trap was delivered |
| nmi_en_clr_o | output | 1 | One-cycle pulse: clear the NMI enable (redirect taken) |
| nmi_epc_o | output | PC_W | NMI exception pc |
| nmi_cause_o | output | CAUSE_W | NMI cause |
| nmi_prev_mode_o | output | 2 | NMI previous-mode field |
| halt_o | output | 1 | Stop execution |
| irq_mask_o | output | 1 | Mask every interrupt including NMIs |
| crit_err_o | output | 1 | Critical-error signal to the platform |

## Verification
Every result of this block is registered once. An input applied before a clock edge shows its effect on the outputs straight after that edge, and pulse outputs drop again after the next edge. The bench changes inputs 2 ns after each rising edge. A behavioural reference model steps on the same rising edge from the inputs held across it, and its predictions are compared with both layout instances at the following falling edge. Scenario checks sample 2 ns after the edge that captured the stimulus, so each pulse is seen in its only valid cycle. Reset is applied mid-run with the comparison paused, which shows that the critical-error state is left only through reset.

// File: rtl/mdt_esc_pkg.sv
package mdt_esc_pkg;
   typedef enum logic {
      LAYOUT_SPLIT = 1'b0,
      LAYOUT_WIDE  = 1'b1
   } status_layout_e;

   typedef enum logic [1:0] {
      TC_NONE     = 2'd0,
      TC_EXPECTED = 2'd1,
      TC_TO_NMI   = 2'd2,
      TC_FATAL    = 2'd3
   } trap_class_e;

   localparam logic [1:0] PRIV_MACHINE = 2'b11;
endpackage

// File: rtl/mdt_trap_class.sv
module mdt_trap_class
   import mdt_esc_pkg::*;
(
   input  logic        trap_req,
   input  logic        frozen,
   input  logic        mdt,
   input  logic        trap_in_m,
   input  logic        nmi_resumable,
   input  logic        nmi_en,
   output trap_class_e cls
);
   logic nested;
   logic nmi_blocked;

   always_comb begin
      nmi_blocked = nmi_resumable & trap_in_m & ~nmi_en;
      nested      = mdt | nmi_blocked;
      cls         = TC_NONE;
      if (trap_req && !frozen) begin
         if (!nested)                       cls = TC_EXPECTED;
         else if (nmi_resumable && nmi_en)  cls = TC_TO_NMI;
         else                               cls = TC_FATAL;
      end
   end
endmodule

// File: rtl/mdt_status_ctl.sv
module mdt_status_ctl
   import mdt_esc_pkg::*;
#(
   parameter status_layout_e LAYOUT = LAYOUT_WIDE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frozen,
   input  logic trap_req,
   input  logic trap_expected,
   input  logic mret_retire,
   input  logic st_we,
   input  logic st_mie_d,
   input  logic st_mdt_d,
   input  logic sth_we,
   input  logic sth_mdt_d,
   output logic mdt,
   output logic mie
);
   logic mdt_q, mie_q, mdt_n, mie_n;
   logic flag_wr_en, flag_wr_val, ie_wr_en, ie_wr_val;

   generate
      if (LAYOUT == LAYOUT_WIDE) begin : g_wide
         logic unused_hi;
         assign unused_hi   = sth_we ^ sth_mdt_d;
         assign flag_wr_en  = st_we;
         assign flag_wr_val = st_mdt_d;
         assign ie_wr_en    = st_we;
         assign ie_wr_val   = st_mie_d & ~st_mdt_d;
      end else begin : g_split
         logic unused_lo;
         assign unused_lo   = st_mdt_d;
         assign flag_wr_en  = sth_we;
         assign flag_wr_val = sth_mdt_d;
         assign ie_wr_en    = (sth_we & sth_mdt_d) | st_we;
         assign ie_wr_val   = (sth_we & sth_mdt_d) ? 1'b0 : (st_mie_d & ~mdt_q);
      end
   endgenerate

   always_comb begin
      mdt_n = mdt_q;
      mie_n = mie_q;
      if (!frozen) begin
         if (trap_req) begin
            if (trap_expected) mdt_n = 1'b1;
         end else if (mret_retire) begin
            mdt_n = 1'b0;
         end else begin
            if (flag_wr_en) mdt_n = flag_wr_val;
            if (ie_wr_en)   mie_n = ie_wr_val;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdt_q <= 1'b1;
         mie_q <= 1'b0;
      end else begin
         mdt_q <= mdt_n;
         mie_q <= mie_n;
      end
   end

   assign mdt = mdt_q;
   assign mie = mie_q;
endmodule

// File: rtl/mdt_nmi_capture.sv
module mdt_nmi_capture
   import mdt_esc_pkg::*;
#(
   parameter int PC_W    = 32,
   parameter int CAUSE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap_en,
   input  logic [PC_W-1:0]    pc_d,
   input  logic [CAUSE_W-1:0] cause_d,
   output logic [PC_W-1:0]    epc_q,
   output logic [CAUSE_W-1:0] cause_q,
   output logic [1:0]         prev_mode_q,
   output logic               en_clr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         epc_q       <= '0;
         cause_q     <= '0;
         prev_mode_q <= '0;
         en_clr_q    <= 1'b0;
      end else begin
         en_clr_q <= cap_en;
         if (cap_en) begin
            epc_q       <= pc_d;
            cause_q     <= cause_d;
            prev_mode_q <= PRIV_MACHINE;
         end
      end
   end
endmodule

// File: rtl/mdt_escalate.sv
module mdt_escalate
   import mdt_esc_pkg::*;
#(
   parameter status_layout_e LAYOUT  = LAYOUT_WIDE,
   parameter int             PC_W    = 32,
   parameter int             CAUSE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               st_we,
   input  logic               st_mie_d,
   input  logic               st_mdt_d,
   input  logic               sth_we,
   input  logic               sth_mdt_d,
   input  logic               trap_req,
   input  logic               trap_in_m,
   input  logic [CAUSE_W-1:0] trap_cause,
   input  logic [PC_W-1:0]    trap_pc,
   input  logic               mret_retire,
   input  logic               nmi_resumable,
   input  logic               nmi_en,
   output logic               mdt_o,
   output logic               mie_o,
   output logic               trap_ok_o,
   output logic               nmi_en_clr_o,
   output logic [PC_W-1:0]    nmi_epc_o,
   output logic [CAUSE_W-1:0] nmi_cause_o,
   output logic [1:0]         nmi_prev_mode_o,
   output logic               halt_o,
   output logic               irq_mask_o,
   output logic               crit_err_o
);
   localparam int MIN_PC_W = 2;

   generate
      if (PC_W < MIN_PC_W || PC_W > 64) begin : g_bad_pc
         $error("mdt_escalate: PC_W out of range");
      end
      if (CAUSE_W < 5 || CAUSE_W > 64) begin : g_bad_cause
         $error("mdt_escalate: CAUSE_W out of range");
      end
   endgenerate

   trap_class_e cls;
   logic        crit_q;
   logic        ok_q;

   mdt_trap_class u_class (
      .trap_req      (trap_req),
      .frozen        (crit_q),
      .mdt           (mdt_o),
      .trap_in_m     (trap_in_m),
      .nmi_resumable (nmi_resumable),
      .nmi_en        (nmi_en),
      .cls           (cls)
   );

   mdt_status_ctl #(.LAYOUT(LAYOUT)) u_status (
      .clk           (clk),
      .rst_n         (rst_n),
      .frozen        (crit_q),
      .trap_req      (trap_req),
      .trap_expected (cls == TC_EXPECTED),
      .mret_retire   (mret_retire),
      .st_we         (st_we),
      .st_mie_d      (st_mie_d),
      .st_mdt_d      (st_mdt_d),
      .sth_we        (sth_we),
      .sth_mdt_d     (sth_mdt_d),
      .mdt           (mdt_o),
      .mie           (mie_o)
   );

   mdt_nmi_capture #(.PC_W(PC_W), .CAUSE_W(CAUSE_W)) u_nmi (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_en      (cls == TC_TO_NMI),
      .pc_d        (trap_pc),
      .cause_d     (trap_cause),
      .epc_q       (nmi_epc_o),
      .cause_q     (nmi_cause_o),
      .prev_mode_q (nmi_prev_mode_o),
      .en_clr_q    (nmi_en_clr_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crit_q <= 1'b0;
         ok_q   <= 1'b0;
      end else begin
         crit_q <= crit_q | (cls == TC_FATAL);
         ok_q   <= (cls == TC_EXPECTED);
      end
   end

   assign trap_ok_o  = ok_q;
   assign crit_err_o = crit_q;
   assign halt_o     = crit_q;
   assign irq_mask_o = crit_q;
endmodule

// File: rtl/mdt_escalate_chk.sv
module mdt_escalate_chk
   import mdt_esc_pkg::*;
#(
   parameter status_layout_e LAYOUT  = LAYOUT_WIDE,
   parameter int             PC_W    = 32,
   parameter int             CAUSE_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               st_we,
   input logic               st_mie_d,
   input logic               st_mdt_d,
   input logic               sth_we,
   input logic               sth_mdt_d,
   input logic               trap_req,
   input logic               trap_in_m,
   input logic [CAUSE_W-1:0] trap_cause,
   input logic [PC_W-1:0]    trap_pc,
   input logic               mret_retire,
   input logic               nmi_resumable,
   input logic               nmi_en,
   input logic               mdt_o,
   input logic               mie_o,
   input logic               trap_ok_o,
   input logic               nmi_en_clr_o,
   input logic [PC_W-1:0]    nmi_epc_o,
   input logic [CAUSE_W-1:0] nmi_cause_o,
   input logic [1:0]         nmi_prev_mode_o,
   input logic               halt_o,
   input logic               irq_mask_o,
   input logic               crit_err_o
);
   AST_CRIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      crit_err_o |=> crit_err_o); // R9

   AST_CRIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      crit_err_o |=> ($stable(mdt_o) && $stable(mie_o) && $stable(nmi_epc_o) && !trap_ok_o && !nmi_en_clr_o)); // R9

   AST_MRET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (mret_retire && !trap_req && !crit_err_o) |=> !mdt_o); // R10

   AST_EXPECTED_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && !crit_err_o && !mdt_o && !(nmi_resumable && trap_in_m && !nmi_en))
      |=> (mdt_o && trap_ok_o)); // R5

   AST_NMI_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && !crit_err_o && mdt_o && nmi_resumable && nmi_en)
      |=> (nmi_en_clr_o && nmi_prev_mode_o == 2'b11 && nmi_epc_o == $past(trap_pc)
           && nmi_cause_o == $past(trap_cause) && mdt_o)); // R6

   AST_FATAL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && !crit_err_o && mdt_o && !nmi_resumable) |=> (crit_err_o && halt_o && irq_mask_o)); // R8

   AST_NMI_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && !crit_err_o && nmi_resumable && trap_in_m && !nmi_en) |=> crit_err_o); // R7

   generate
      if (LAYOUT == LAYOUT_WIDE) begin : g_wide_chk
         AST_WIDE_MIE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (st_we && st_mdt_d && !trap_req && !mret_retire && !crit_err_o) |=> !mie_o); // R2
         AST_WIDE_MIE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(mie_o) |-> ($past(st_we) && !$past(st_mdt_d) && $past(st_mie_d))); // R3
      end else begin : g_split_chk
         AST_SPLIT_MIE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (sth_we && sth_mdt_d && !trap_req && !mret_retire && !crit_err_o) |=> (!mie_o && mdt_o)); // R4
         AST_SPLIT_MIE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(mie_o) |-> ($past(st_we) && !$past(mdt_o) && $past(st_mie_d))); // R3
      end
   endgenerate
endmodule

bind mdt_escalate mdt_escalate_chk #(.LAYOUT(LAYOUT), .PC_W(PC_W), .CAUSE_W(CAUSE_W)) chk_i (.*);

// File: tb/mdt_escalate_tb_top.sv
`timescale 1ns/1ps
module mdt_escalate_tb_top;
   import mdt_esc_pkg::*;

   localparam int PC_W    = 32;
   localparam int CAUSE_W = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0;
   logic st_we = 0, st_mie_d = 0, st_mdt_d = 0, sth_we = 0, sth_mdt_d = 0;
   logic trap_req = 0, trap_in_m = 0, mret_retire = 0, nmi_resumable = 0, nmi_en = 0;
   logic [CAUSE_W-1:0] trap_cause = '0;
   logic [PC_W-1:0]    trap_pc = '0;

   logic               o_mdt [2];
   logic               o_mie [2];
   logic               o_ok  [2];
   logic               o_clr [2];
   logic [PC_W-1:0]    o_epc [2];
   logic [CAUSE_W-1:0] o_cau [2];
   logic [1:0]         o_pm  [2];
   logic               o_halt [2];
   logic               o_msk [2];
   logic               o_crit [2];

   mdt_escalate #(.LAYOUT(LAYOUT_WIDE), .PC_W(PC_W), .CAUSE_W(CAUSE_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .st_we(st_we), .st_mie_d(st_mie_d), .st_mdt_d(st_mdt_d),
      .sth_we(sth_we), .sth_mdt_d(sth_mdt_d), .trap_req(trap_req), .trap_in_m(trap_in_m),
      .trap_cause(trap_cause), .trap_pc(trap_pc), .mret_retire(mret_retire),
      .nmi_resumable(nmi_resumable), .nmi_en(nmi_en),
      .mdt_o(o_mdt[0]), .mie_o(o_mie[0]), .trap_ok_o(o_ok[0]), .nmi_en_clr_o(o_clr[0]),
      .nmi_epc_o(o_epc[0]), .nmi_cause_o(o_cau[0]), .nmi_prev_mode_o(o_pm[0]),
      .halt_o(o_halt[0]), .irq_mask_o(o_msk[0]), .crit_err_o(o_crit[0]));

   mdt_escalate #(.LAYOUT(LAYOUT_SPLIT), .PC_W(PC_W), .CAUSE_W(CAUSE_W)) dut_n_i (
      .clk(clk), .rst_n(rst_n), .st_we(st_we), .st_mie_d(st_mie_d), .st_mdt_d(st_mdt_d),
      .sth_we(sth_we), .sth_mdt_d(sth_mdt_d), .trap_req(trap_req), .trap_in_m(trap_in_m),
      .trap_cause(trap_cause), .trap_pc(trap_pc), .mret_retire(mret_retire),
      .nmi_resumable(nmi_resumable), .nmi_en(nmi_en),
      .mdt_o(o_mdt[1]), .mie_o(o_mie[1]), .trap_ok_o(o_ok[1]), .nmi_en_clr_o(o_clr[1]),
      .nmi_epc_o(o_epc[1]), .nmi_cause_o(o_cau[1]), .nmi_prev_mode_o(o_pm[1]),
      .halt_o(o_halt[1]), .irq_mask_o(o_msk[1]), .crit_err_o(o_crit[1]));

   int nchk = 0;
   int nerr = 0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Behavioural reference: index 0 = wide layout, index 1 = split layout
   bit               r_mdt [2];
   bit               r_mie [2];
   bit               r_ok  [2];
   bit               r_clr [2];
   bit [PC_W-1:0]    r_epc [2];
   bit [CAUSE_W-1:0] r_cau [2];
   bit [1:0]         r_pm  [2];
   bit               r_crit [2];

   always @(posedge clk) begin
      for (int k = 0; k < 2; k++) begin
         if (!rst_n) begin
            r_mdt[k] = 1; r_mie[k] = 0; r_ok[k] = 0; r_clr[k] = 0;
            r_epc[k] = 0; r_cau[k] = 0; r_pm[k] = 0; r_crit[k] = 0;
         end else begin
            r_ok[k] = 0;
            r_clr[k] = 0;
            if (!r_crit[k]) begin
               if (trap_req) begin
                  if (!r_mdt[k] && !(nmi_resumable && trap_in_m && !nmi_en)) begin
                     r_mdt[k] = 1; r_ok[k] = 1;
                  end else if (nmi_resumable && nmi_en) begin
                     r_epc[k] = trap_pc; r_cau[k] = trap_cause; r_pm[k] = 2'b11; r_clr[k] = 1;
                  end else begin
                     r_crit[k] = 1;
                  end
               end else if (mret_retire) begin
                  r_mdt[k] = 0;
               end else if (k == 0) begin
                  if (st_we) begin
                     r_mdt[k] = st_mdt_d;
                     r_mie[k] = st_mdt_d ? 1'b0 : st_mie_d;
                  end
               end else begin
                  if (sth_we && sth_mdt_d) begin
                     r_mdt[k] = 1; r_mie[k] = 0;
                  end else begin
                     if (st_we) r_mie[k] = st_mie_d && !r_mdt[k];
                     if (sth_we) r_mdt[k] = 0;
                  end
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         for (int k = 0; k < 2; k++) begin
            chk("R10 model mdt", o_mdt[k], r_mdt[k]);
            chk("R3 model mie", o_mie[k], r_mie[k]);
            chk("R5 model trap_ok", o_ok[k], r_ok[k]);
            chk("R6 model nmi", {o_clr[k], o_pm[k], o_cau[k], o_epc[k]},
                {r_clr[k], r_pm[k], r_cau[k], r_epc[k]});
            chk("R8 model crit", {o_crit[k], o_halt[k], o_msk[k]},
                {r_crit[k], r_crit[k], r_crit[k]});
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #2;
      st_we = 0; sth_we = 0; trap_req = 0; mret_retire = 0;
   endtask

   initial begin
      #(20 * 5000);
      nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      // R1 reset state
      for (int k = 0; k < 2; k++) begin
         chk("R1 mdt", o_mdt[k], 1);
         chk("R1 mie", o_mie[k], 0);
         chk("R1 crit", {o_crit[k], o_halt[k], o_msk[k], o_ok[k], o_clr[k]}, 0);
         chk("R1 nmi regs", {o_epc[k], o_cau[k], o_pm[k]}, 0);
      end
      // R2 / R3: write mie=1 with flag=1
      st_we = 1; st_mie_d = 1; st_mdt_d = 1; tick();
      chk("R2 wide mie", o_mie[0], 0);
      chk("R3 split mie blocked", o_mie[1], 0);
      // R3: wide write clears flag and sets mie together
      st_we = 1; st_mie_d = 1; st_mdt_d = 0; tick();
      chk("R3 wide mie", {o_mdt[0], o_mie[0]}, 2'b01);
      chk("R3 split still blocked", {o_mdt[1], o_mie[1]}, 2'b10);
      sth_we = 1; sth_mdt_d = 0; tick();
      chk("R4 split hi clear", o_mdt[1], 0);
      st_we = 1; st_mie_d = 1; st_mdt_d = 0; tick();
      chk("R3 split mie set", o_mie[1], 1);
      // R4: hi write sets flag with a competing low write
      sth_we = 1; sth_mdt_d = 1; st_we = 1; st_mie_d = 1; st_mdt_d = 0; tick();
      chk("R4 split", {o_mdt[1], o_mie[1]}, 2'b10);
      chk("R4 wide ignores hi", {o_mdt[0], o_mie[0]}, 2'b01);
      // R10
      mret_retire = 1; tick();
      chk("R10 mret", {o_mdt[0], o_mdt[1]}, 2'b00);
      // R5 / R7: trap from lower mode with nmi_en low is expected
      nmi_resumable = 1; nmi_en = 0; trap_in_m = 0;
      trap_req = 1; trap_cause = 8'h05; trap_pc = 32'h100; tick();
      chk("R5 trap_ok", {o_ok[0], o_ok[1]}, 2'b11);
      chk("R7 lower mode expected", {o_mdt[0], o_crit[0]}, 2'b10);
      tick();
      chk("R5 pulse ends", o_ok[0], 0);
      // R6 / R11: nested trap with mret and write in same cycle
      nmi_en = 1; trap_in_m = 1; trap_req = 1; mret_retire = 1;
      st_we = 1; st_mdt_d = 0; st_mie_d = 0;
      trap_cause = 8'h2A; trap_pc = 32'h2000; tick();
      chk("R6 epc", o_epc[0], 32'h2000);
      chk("R6 cause", o_cau[1], 8'h2A);
      chk("R6 prev mode", o_pm[0], 2'b11);
      chk("R6 clr pulse", {o_clr[0], o_ok[0]}, 2'b10);
      chk("R11 trap wins", {o_mdt[0], o_mie[0]}, 2'b11);
      tick();
      chk("R6 clr ends", o_clr[0], 0);
      // R11: mret outranks write
      mret_retire = 1; st_we = 1; st_mdt_d = 1; st_mie_d = 0; tick();
      chk("R11 mret wins", {o_mdt[0], o_mie[0]}, 2'b01);
      // R7: trap in M with nmi_en low while flag clear
      nmi_en = 0; trap_req = 1; trap_cause = 8'h07; trap_pc = 32'h3000; tick();
      chk("R7 crit", {o_crit[0], o_crit[1]}, 2'b11);
      chk("R8 halt mask", {o_halt[0], o_msk[0]}, 2'b11);
      chk("R8 no update", {o_mdt[0], o_epc[0]}, {1'b0, 32'h2000});
      // R9: frozen state ignores everything
      mret_retire = 1; tick();
      st_we = 1; st_mdt_d = 1; st_mie_d = 0; tick();
      nmi_en = 1; trap_req = 1; trap_pc = 32'h4000; tick();
      chk("R9 frozen mie", o_mie[0], 1);
      chk("R9 frozen nmi", {o_clr[0], o_epc[0]}, {1'b0, 32'h2000});
      chk("R9 sticky", o_crit[0], 1);
      // R9: only reset leaves
      rst_n = 0; tick(); tick();
      rst_n = 1;
      chk("R9 reset exits", {o_crit[0], o_crit[1], o_mdt[0]}, 3'b001);
      // R8: no resumable NMI support, nested trap
      nmi_resumable = 0; nmi_en = 1; trap_in_m = 0; trap_req = 1; trap_pc = 32'h5000; tick();
      chk("R8 fatal", {o_crit[0], o_crit[1], o_halt[1], o_msk[1]}, 4'hF);
      chk("R8 nmi untouched", {o_epc[1], o_clr[1]}, {32'h0, 1'b0});
      tick();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule